// File: doc/BRIEF.md
# Banked Branch Record Buffer

The block records taken branches reported by the core. Each recorded branch is stored as three values: a source address, a target address and an info word. The newest record always sits at index 0, older records move one place up on every capture, and the oldest one falls off once the buffer is full. The capacity is a parameter and may be 8, 16, 32 or 64 records.

Software reads the buffer through a 32-entry window. A bank bit in the filter register selects which group of 32 records the window shows. Capture is gated in several ways:
- a type-enable bit for each of six ordinary branch classes;
- separate enables for exception entry and exception return;
- an enable for user level and an enable for the kernel/hypervisor levels.

An exception that crosses into a disabled level is still recorded, but the address on the disabled side is zeroed and the validity code says which half is valid. Recording can be stopped with a pause bit. It can also be frozen when an external counter overflows. An invalidate command clears every record.

Top module: `branch_rec_buf`

## Requirements
- R1: After reset, every read index returns all-zero source, target and info. The filter register is paused with all type enables clear, and every control enable is clear.
- R2: Branch type codes are 0 direct unconditional, 1 indirect jump, 2 direct call, 3 indirect call, 4 return, 5 conditional direct, 6 exception entry and 7 exception return. Filter bits [5:0] enable types 0 to 5 by bit index. Control bit 2 enables type 6 and control bit 3 enables type 7. A branch whose enable is clear is not recorded.
- R3: A captured branch is written at index 0 and every older record moves up by one index. When the buffer is full the oldest record is dropped, so valid records are contiguous from index 0.
- R4: Filter bit 7 is the bank bit. The read index (0 to 31) addresses record bank*32+index, and an address at or beyond the capacity reads as all zero.
- R5: Levels are 0 user and 1 to 3 kernel/hypervisor. Control bit 0 enables user and control bit 1 enables the others. An exception entry or return is recorded when at least one side's level is enabled. A disabled side has its address forced to zero, and the validity code (info[1:0]) is bit0 for source valid and bit1 for target valid.
- R6: An ordinary branch (types 0 to 5) is recorded only when both its source and target levels are enabled, and then with validity code 3.
- R7: Invalidate clears every record. A branch captured in the same cycle becomes the only valid record, at index 0.
- R8: While filter bit 6 (pause) is set, nothing is recorded. A filter write with bit 6 clear resumes recording from the next cycle.
- R9: With control bit 6 (freeze) set, an asserted overflow input sets the pause bit. This also applies when a resume write arrives in the same cycle. A branch presented in that cycle is not recorded.
- R10: The info word is laid out as [4:2] type, [6:5] level of the target (0 when the target is invalid), [7] mispredict, [15:8] cycle mantissa, [19:16] cycle exponent and [20] count-unknown. The mispredict bit is stored only when control bit 4 is set and the source is valid. The cycle fields are stored only when control bit 5 is set; otherwise they are zero.
- R11: A cycle count below 256 is stored with exponent 0 and the count as mantissa. A larger count C is stored with exponent e and mantissa m such that C >> (e-1) = 256+m. A set count-unknown input stores bit 20 set with exponent and mantissa zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Branch event present this cycle |
| br_type_i | input | 3 | Branch type code |
| br_src_lvl_i | input | 2 | Privilege level at the source |
| br_tgt_lvl_i | input | 2 | Privilege level at the target |
| br_src_i | input | ADDR_W | Source address |
| br_tgt_i | input | ADDR_W | Target address |
| br_mispred_i | input | 1 | Branch was mispredicted |
| br_cyc_i | input | 16 | Cycles since the previous branch |
| br_cyc_unk_i | input | 1 | Cycle count is unknown |
| flt_we_i | input | 1 | Write strobe for the filter register |
| flt_wdata_i | input | 8 | Filter value: type enables, pause, bank |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 7 | Control value: level, exception, field and freeze enables |
| inval_i | input | 1 | Invalidate all records |
| ovf_i | input | 1 | External counter overflow |
| rd_idx_i | input | 5 | Read index within the selected bank |
| rd_src_o | output | ADDR_W | Source address of the addressed record |
| rd_tgt_o | output | ADDR_W | Target address of the addressed record |
| rd_info_o | output | 21 | Info word of the addressed record |

## Verification
Two collisions matter most. The first is capture and invalidate in the same cycle: the bench presents a qualifying branch together with the invalidate strobe and expects exactly one valid record, at index 0, with every higher index reading zero. The second is an overflow with freeze enabled landing in the same cycle as a resume write and a branch. Here the pause must win, the branch must be dropped, and a following branch must also be dropped until a clean resume write. Random stimulus also produces these overlaps, and the same reference model judges them, so the outcome of the collision is fixed by the requirements and not by the order of processes.

// File: rtl/brb_pkg.sv
package brb_pkg;
  localparam int TYPE_W     = 3;
  localparam int LVL_W      = 2;
  localparam int CYC_W      = 16;
  localparam int BANK_SZ    = 32;
  localparam int BANK_IDX_W = $clog2(BANK_SZ);
  localparam int FLT_W      = 8;
  localparam int CTL_W      = 7;
  localparam int MANT_W     = 8;
  localparam int EXP_W      = 4;

  // info word layout
  localparam int VLD_LSB  = 0;
  localparam int TY_LSB   = 2;
  localparam int LV_LSB   = TY_LSB + TYPE_W;
  localparam int MP_BIT   = LV_LSB + LVL_W;
  localparam int MANT_LSB = MP_BIT + 1;
  localparam int EXP_LSB  = MANT_LSB + MANT_W;
  localparam int CCU_BIT  = EXP_LSB + EXP_W;
  localparam int INFO_W   = CCU_BIT + 1;

  localparam logic [TYPE_W-1:0] TY_EXC  = 3'd6;
  localparam logic [TYPE_W-1:0] TY_ERET = 3'd7;

  typedef struct packed {
    logic       bank;
    logic       pause;
    logic [5:0] ty_en;
  } flt_t;

  typedef struct packed {
    logic freeze_en;
    logic cc_en;
    logic mpred_en;
    logic eret_en;
    logic exc_en;
    logic kern_en;
    logic user_en;
  } ctl_t;
endpackage

// File: rtl/brb_cyc_enc.sv
module brb_cyc_enc import brb_pkg::*; (
  input  logic [CYC_W-1:0]  cyc_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0] mant_o
);
  always_comb begin
    exp_o  = '0;
    mant_o = cyc_i[MANT_W-1:0];
    // ascending scan: highest set bit wins
    for (int p = MANT_W; p < CYC_W; p++) begin
      if (cyc_i[p]) begin
        exp_o  = EXP_W'(p - MANT_W + 1);
        mant_o = MANT_W'(cyc_i >> (p - MANT_W));
      end
    end
  end
endmodule

// File: rtl/brb_filter.sv
module brb_filter import brb_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  flt_t              flt_i,
  input  ctl_t              ctl_i,
  input  logic              valid_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [LVL_W-1:0]  src_lvl_i,
  input  logic [LVL_W-1:0]  tgt_lvl_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              mispred_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic              cyc_unk_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [INFO_W-1:0] info_o
);
  logic [EXP_W-1:0]  cexp;
  logic [MANT_W-1:0] cmant;
  logic              src_ok, tgt_ok, gate, is_x;
  logic [1:0]        vld;
  logic [7:0]        ty_vec;

  brb_cyc_enc i_enc (.cyc_i(cyc_i), .exp_o(cexp), .mant_o(cmant));

  function automatic logic lvl_en(input ctl_t c, input logic [LVL_W-1:0] l);
    return (l == '0) ? c.user_en : c.kern_en;
  endfunction

  always_comb begin
    src_ok = lvl_en(ctl_i, src_lvl_i);
    tgt_ok = lvl_en(ctl_i, tgt_lvl_i);
    ty_vec = {ctl_i.eret_en, ctl_i.exc_en, flt_i.ty_en};
    gate   = ty_vec[type_i];
    is_x   = (type_i == TY_EXC) || (type_i == TY_ERET);
    // exceptions keep the enabled half; ordinary branches need both sides
    if (is_x) vld = {tgt_ok, src_ok};
    else      vld = (src_ok && tgt_ok) ? 2'b11 : 2'b00;
    hit_o = valid_i && gate && (vld != 2'b00);
    src_o = vld[0] ? src_i : '0;
    tgt_o = vld[1] ? tgt_i : '0;

    info_o = '0;
    info_o[VLD_LSB +: 2]     = vld;
    info_o[TY_LSB +: TYPE_W] = type_i;
    info_o[LV_LSB +: LVL_W]  = vld[1] ? tgt_lvl_i : '0;
    info_o[MP_BIT]           = ctl_i.mpred_en && mispred_i && vld[0];
    if (ctl_i.cc_en) begin
      if (cyc_unk_i) begin
        info_o[CCU_BIT] = 1'b1;
      end else begin
        info_o[MANT_LSB +: MANT_W] = cmant;
        info_o[EXP_LSB +: EXP_W]   = cexp;
      end
    end
  end
endmodule

// File: rtl/brb_store.sv
module brb_store import brb_pkg::*; #(
  parameter int NUM_REC = 32,
  parameter int ADDR_W  = 32,
  parameter int RD_W    = BANK_IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              inval_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [RD_W-1:0]   rd_addr_i,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_tgt_o,
  output logic [INFO_W-1:0] rd_info_o
);
  localparam int IW = $clog2(NUM_REC);

  logic [ADDR_W-1:0] src_q  [NUM_REC];
  logic [ADDR_W-1:0] tgt_q  [NUM_REC];
  logic [INFO_W-1:0] info_q [NUM_REC];

  for (genvar i = 0; i < NUM_REC; i++) begin : g_ent
    logic [ADDR_W-1:0] src_d, tgt_d;
    logic [INFO_W-1:0] info_d;
    if (i == 0) begin : g_head
      assign src_d  = src_i;
      assign tgt_d  = tgt_i;
      assign info_d = info_i;
    end else begin : g_body
      assign src_d  = inval_i ? '0 : src_q[i-1];
      assign tgt_d  = inval_i ? '0 : tgt_q[i-1];
      assign info_d = inval_i ? '0 : info_q[i-1];

      p_contig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (info_q[i][1:0] != 2'b00) |-> (info_q[i-1][1:0] != 2'b00));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]  <= '0;
        tgt_q[i]  <= '0;
        info_q[i] <= '0;
      end else if (push_i) begin
        src_q[i]  <= src_d;
        tgt_q[i]  <= tgt_d;
        info_q[i] <= info_d;
      end else if (inval_i) begin
        src_q[i]  <= '0;
        tgt_q[i]  <= '0;
        info_q[i] <= '0;
      end
    end
  end

  always_comb begin
    rd_src_o  = '0;
    rd_tgt_o  = '0;
    rd_info_o = '0;
    if (int'(rd_addr_i) < NUM_REC) begin
      rd_src_o  = src_q[rd_addr_i[IW-1:0]];
      rd_tgt_o  = tgt_q[rd_addr_i[IW-1:0]];
      rd_info_o = info_q[rd_addr_i[IW-1:0]];
    end
  end

  p_head_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (src_q[0] == $past(src_i)) && (info_q[0] == $past(info_i)));
  p_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_i && !push_i) |=> (info_q[0] == '0) && (info_q[NUM_REC-1] == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !inval_i) |=> $stable(info_q[0]) && $stable(src_q[0]));
endmodule

// File: rtl/branch_rec_buf.sv
module branch_rec_buf import brb_pkg::*; #(
  parameter int NUM_REC = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  br_valid_i,
  input  logic [TYPE_W-1:0]     br_type_i,
  input  logic [LVL_W-1:0]      br_src_lvl_i,
  input  logic [LVL_W-1:0]      br_tgt_lvl_i,
  input  logic [ADDR_W-1:0]     br_src_i,
  input  logic [ADDR_W-1:0]     br_tgt_i,
  input  logic                  br_mispred_i,
  input  logic [CYC_W-1:0]      br_cyc_i,
  input  logic                  br_cyc_unk_i,
  input  logic                  flt_we_i,
  input  logic [FLT_W-1:0]      flt_wdata_i,
  input  logic                  ctl_we_i,
  input  logic [CTL_W-1:0]      ctl_wdata_i,
  input  logic                  inval_i,
  input  logic                  ovf_i,
  input  logic [BANK_IDX_W-1:0] rd_idx_i,
  output logic [ADDR_W-1:0]     rd_src_o,
  output logic [ADDR_W-1:0]     rd_tgt_o,
  output logic [INFO_W-1:0]     rd_info_o
);
  localparam flt_t FLT_RST = '{bank: 1'b0, pause: 1'b1, ty_en: '0};

  flt_t              flt_q, flt_w;
  ctl_t              ctl_q;
  logic              hit, push, freeze;
  logic [ADDR_W-1:0] f_src, f_tgt;
  logic [INFO_W-1:0] f_info;

  assign flt_w  = flt_t'(flt_wdata_i);
  assign freeze = ovf_i && ctl_q.freeze_en;
  assign push   = hit && !flt_q.pause && !freeze;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= FLT_RST;
      ctl_q <= '0;
    end else begin
      if (flt_we_i) flt_q <= flt_w;
      if (freeze)   flt_q.pause <= 1'b1;  // freeze beats a resume write
      if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i);
    end
  end

  brb_filter #(.ADDR_W(ADDR_W)) i_filter (
    .flt_i(flt_q), .ctl_i(ctl_q), .valid_i(br_valid_i), .type_i(br_type_i),
    .src_lvl_i(br_src_lvl_i), .tgt_lvl_i(br_tgt_lvl_i),
    .src_i(br_src_i), .tgt_i(br_tgt_i), .mispred_i(br_mispred_i),
    .cyc_i(br_cyc_i), .cyc_unk_i(br_cyc_unk_i),
    .hit_o(hit), .src_o(f_src), .tgt_o(f_tgt), .info_o(f_info)
  );

  brb_store #(.NUM_REC(NUM_REC), .ADDR_W(ADDR_W)) i_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .inval_i(inval_i),
    .src_i(f_src), .tgt_i(f_tgt), .info_i(f_info),
    .rd_addr_i({flt_q.bank, rd_idx_i}),
    .rd_src_o(rd_src_o), .rd_tgt_o(rd_tgt_o), .rd_info_o(rd_info_o)
  );

  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze |=> flt_q.pause);
  p_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_we_i && !flt_w.pause && !freeze) |=> !flt_q.pause);
  p_src_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && f_info[1:0] == 2'b01) |-> (f_tgt == '0));
  p_tgt_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && f_info[1:0] == 2'b10) |-> (f_src == '0));
  p_cyc_small_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && ctl_q.cc_en && !br_cyc_unk_i && br_cyc_i < 16'd256) |->
      (f_info[EXP_LSB +: EXP_W] == '0) && (f_info[MANT_LSB +: MANT_W] == br_cyc_i[7:0]));
  p_mpred_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !ctl_q.mpred_en) |-> !f_info[MP_BIT]);
endmodule

// File: tb/test_branch_rec_buf.sv
module test_branch_rec_buf;
  import brb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NREC = 64;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic b_v = 0, b_mp = 0, b_unk = 0, f_we = 0, c_we = 0, inv = 0, ovf = 0;
  logic [2:0] b_ty = 0;
  logic [1:0] b_sl = 0, b_tl = 0;
  logic [AW-1:0] b_src = 0, b_tgt = 0;
  logic [15:0] b_cyc = 0;
  logic [7:0] f_wd = 0;
  logic [6:0] c_wd = 0;
  logic [4:0] rd_idx = 0;
  logic [AW-1:0] r_src, r_tgt;
  logic [INFO_W-1:0] r_info;

  branch_rec_buf #(.NUM_REC(NREC), .ADDR_W(AW)) i_branch_rec_buf (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(b_v), .br_type_i(b_ty),
    .br_src_lvl_i(b_sl), .br_tgt_lvl_i(b_tl), .br_src_i(b_src), .br_tgt_i(b_tgt),
    .br_mispred_i(b_mp), .br_cyc_i(b_cyc), .br_cyc_unk_i(b_unk),
    .flt_we_i(f_we), .flt_wdata_i(f_wd), .ctl_we_i(c_we), .ctl_wdata_i(c_wd),
    .inval_i(inv), .ovf_i(ovf), .rd_idx_i(rd_idx),
    .rd_src_o(r_src), .rd_tgt_o(r_tgt), .rd_info_o(r_info));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  flt_t m_flt;
  ctl_t m_ctl;
  logic [AW-1:0] m_src [NREC];
  logic [AW-1:0] m_tgt [NREC];
  logic [INFO_W-1:0] m_inf [NREC];

  function automatic void exp_enc(input int c, output logic [3:0] e, output logic [7:0] m);
    int k;
    if (c < 256) begin
      e = 0; m = c[7:0];
    end else begin
      k = 1;
      while ((c >> (k-1)) >= 512) k++;
      e = k[3:0];
      m = 8'((c >> (k-1)) & 255);
    end
  endfunction

  function automatic bit exp_rec(output logic [AW-1:0] es, output logic [AW-1:0] et,
                                 output logic [INFO_W-1:0] ei);
    bit sok, tok, g;
    logic [1:0] vd;
    logic [3:0] e;
    logic [7:0] m;
    sok = (b_sl == 0) ? m_ctl.user_en : m_ctl.kern_en;
    tok = (b_tl == 0) ? m_ctl.user_en : m_ctl.kern_en;
    if (b_ty == 3'd6)      g = m_ctl.exc_en;
    else if (b_ty == 3'd7) g = m_ctl.eret_en;
    else                   g = m_flt.ty_en[b_ty];
    if (b_ty >= 3'd6) vd = {tok, sok};
    else              vd = (sok && tok) ? 2'b11 : 2'b00;
    es = vd[0] ? b_src : '0;
    et = vd[1] ? b_tgt : '0;
    ei = '0;
    ei[1:0] = vd;
    ei[4:2] = b_ty;
    ei[6:5] = vd[1] ? b_tl : 2'b00;
    ei[7] = m_ctl.mpred_en && b_mp && vd[0];
    if (m_ctl.cc_en) begin
      if (b_unk) ei[20] = 1'b1;
      else begin
        exp_enc(int'(b_cyc), e, m);
        ei[15:8] = m;
        ei[19:16] = e;
      end
    end
    return b_v && g && (vd != 2'b00);
  endfunction

  task automatic model_step();
    logic [AW-1:0] es, et;
    logic [INFO_W-1:0] ei;
    bit push;
    push = exp_rec(es, et, ei) && !m_flt.pause && !(ovf && m_ctl.freeze_en);
    if (push) begin
      for (int i = NREC-1; i > 0; i--) begin
        m_src[i] = inv ? '0 : m_src[i-1];
        m_tgt[i] = inv ? '0 : m_tgt[i-1];
        m_inf[i] = inv ? '0 : m_inf[i-1];
      end
      m_src[0] = es; m_tgt[0] = et; m_inf[0] = ei;
    end else if (inv) begin
      for (int i = 0; i < NREC; i++) begin
        m_src[i] = '0; m_tgt[i] = '0; m_inf[i] = '0;
      end
    end
    if (f_we) m_flt = flt_t'(f_wd);
    if (ovf && m_ctl.freeze_en) m_flt.pause = 1'b1;
    if (c_we) m_ctl = ctl_t'(c_wd);
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    @(posedge clk);
    #1;
    b_v = 0; f_we = 0; c_we = 0; inv = 0; ovf = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_flt(input logic [7:0] v); f_we = 1; f_wd = v; cyc(); endtask
  task automatic wr_ctl(input logic [6:0] v); c_we = 1; c_wd = v; cyc(); endtask

  task automatic branch(input logic [2:0] ty, input logic [1:0] sl, input logic [1:0] tl,
                        input logic [AW-1:0] s, input logic [AW-1:0] t,
                        input logic mp, input logic [15:0] cy, input logic unk);
    b_v = 1; b_ty = ty; b_sl = sl; b_tl = tl; b_src = s; b_tgt = t;
    b_mp = mp; b_cyc = cy; b_unk = unk;
    cyc();
  endtask

  // reads record at absolute address a (bank switched through the filter register)
  task automatic rd_abs(input int a);
    flt_t f;
    f = m_flt;
    if (f.bank != a[5]) begin
      f.bank = a[5];
      wr_flt(8'(f));
    end
    rd_idx = a[4:0];
    #1;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 64; a++) begin
      logic [95:0] ex;
      rd_abs(a);
      ex = (a < NREC) ? {m_src[a], m_tgt[a], 32'(m_inf[a])} : '0;
      chk({r_src, r_tgt, 32'(r_info)} == ex, $sformatf("%s idx%0d", tag, a),
          {r_src, r_tgt, 32'(r_info)}, ex);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    logic [7:0] m;
    void'($urandom(32'd2024));
    m_flt = '{bank: 1'b0, pause: 1'b1, ty_en: '0};
    m_ctl = '0;
    for (int i = 0; i < NREC; i++) begin
      m_src[i] = '0; m_tgt[i] = '0; m_inf[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: all records zero after reset; reset pause holds off capture (R8)
    read_all("R1 reset");
    wr_ctl(7'b0000011);
    wr_flt(8'b0111_1111);            // all types, still paused
    branch(3'd0, 2'd1, 2'd1, 32'h1000, 32'h2000, 0, 16'd5, 0);
    rd_abs(0);
    chk(r_info == '0, "R8 paused drop", 96'(r_info), 96'h0);
    wr_flt(8'b0011_1111);            // resume
    branch(3'd0, 2'd1, 2'd1, 32'h1000, 32'h2000, 0, 16'd5, 0);
    rd_abs(0);
    chk(r_src == 32'h1000 && r_info[1:0] == 2'b11, "R8 resume", 96'(r_src), 96'h1000);

    // R2: only conditional direct enabled, exceptions disabled
    inv = 1; cyc();
    wr_flt(8'b0010_0000);
    for (int t = 0; t < 8; t++) branch(3'(t), 2'd1, 2'd1, 32'(t + 16'h100), 32'h3000, 0, 0, 0);
    rd_abs(0);
    chk(r_src == 32'h105 && r_info[4:2] == 3'd5, "R2 cond only", 96'(r_src), 96'h105);
    rd_abs(1);
    chk(r_info == '0, "R2 others dropped", 96'(r_info), 96'h0);

    // R5: user only, exceptions crossing to kernel and back
    wr_ctl(7'b0001101);
    branch(3'd6, 2'd0, 2'd1, 32'hA000, 32'hB000, 1, 0, 0);
    rd_abs(0);
    chk({r_src, r_tgt, 32'(r_info[1:0])} == {32'hA000, 32'h0, 32'h1}, "R5 source only",
        {r_src, r_tgt, 32'(r_info[1:0])}, {32'hA000, 32'h0, 32'h1});
    branch(3'd7, 2'd2, 2'd0, 32'hC000, 32'hD000, 0, 0, 0);
    rd_abs(0);
    chk({r_src, r_tgt, 32'(r_info[6:0])} == {32'h0, 32'hD000, 32'h1E},
        "R5 target only", {r_src, r_tgt, 32'(r_info[6:0])}, {32'h0, 32'hD000, 32'h1E});
    // R6: ordinary branch at disabled kernel level dropped
    branch(3'd5, 2'd1, 2'd1, 32'hE000, 32'hF000, 0, 0, 0);
    rd_abs(0);
    chk(r_tgt == 32'hD000, "R6 disabled level", 96'(r_tgt), 96'hD000);
    read_all("R5 R6 model");

    // R3 R4: overfill, then walk both banks
    wr_ctl(7'b0000011);
    wr_flt(8'b0011_1111);
    for (int i = 0; i < NREC + 6; i++) branch(3'd1, 2'd0, 2'd0, 32'(i), 32'(i + 1000), 0, 0, 0);
    rd_abs(0);
    chk(r_src == 32'(NREC + 5), "R3 newest at 0", 96'(r_src), 96'(NREC + 5));
    rd_abs(NREC - 1);
    chk(r_src == 32'd6, "R3 oldest dropped", 96'(r_src), 96'd6);
    rd_abs(33);
    chk(r_src == 32'(NREC + 5 - 33), "R4 bank1 idx1", 96'(r_src), 96'(NREC + 5 - 33));
    read_all("R3 R4 fill");

    // R7: invalidate together with a capture
    inv = 1;
    branch(3'd2, 2'd0, 2'd0, 32'h5555, 32'h6666, 0, 0, 0);
    rd_abs(0);
    chk(r_src == 32'h5555, "R7 coincident head", 96'(r_src), 96'h5555);
    rd_abs(1);
    chk(r_info == '0, "R7 rest cleared", 96'(r_info), 96'h0);
    inv = 1; cyc();
    rd_abs(0);
    chk(r_info == '0, "R7 invalidate", 96'(r_info), 96'h0);

    // R9: overflow with freeze beats a same-cycle resume write and drops the branch
    wr_ctl(7'b1000011);
    wr_flt(8'b0111_1111);
    ovf = 1; f_we = 1; f_wd = 8'b0011_1111;
    branch(3'd0, 2'd0, 2'd0, 32'h7777, 32'h8888, 0, 0, 0);
    branch(3'd0, 2'd0, 2'd0, 32'h7778, 32'h8888, 0, 0, 0);
    rd_abs(0);
    chk(r_info == '0, "R9 frozen", 96'(r_info), 96'h0);
    wr_flt(8'b0011_1111);
    branch(3'd0, 2'd0, 2'd0, 32'h7779, 32'h8888, 0, 0, 0);
    rd_abs(0);
    chk(r_src == 32'h7779, "R9 resumed", 96'(r_src), 96'h7779);

    // R10 R11: field enables and cycle corners
    wr_ctl(7'b0000011);
    branch(3'd0, 2'd0, 2'd0, 32'h1, 32'h2, 1, 16'd300, 0);
    rd_abs(0);
    chk(r_info[20:7] == '0, "R10 fields off", 96'(r_info), 96'(r_info[6:0]));
    wr_ctl(7'b0110011);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] cv;
      cv = (k == 0) ? 16'd0 : (k == 1) ? 16'd255 : (k == 2) ? 16'd256 :
           (k == 3) ? 16'd511 : (k == 4) ? 16'd4660 : 16'hFFFF;
      branch(3'd0, 2'd0, 2'd0, 32'h1, 32'h2, 1, cv, 0);
      exp_enc(int'(cv), e, m);
      rd_abs(0);
      chk(r_info[19:8] == {e, m} && r_info[7], $sformatf("R11 cyc %0d", cv),
          96'(r_info[19:7]), 96'({e, m, 1'b1}));
    end
    branch(3'd0, 2'd0, 2'd0, 32'h1, 32'h2, 0, 16'd999, 1);
    rd_abs(0);
    chk(r_info[20:8] == 13'h1000, "R11 unknown", 96'(r_info[20:8]), 96'h1000);

    // random mix, all requirements judged by the model
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin f_we = 1; f_wd = 8'($urandom) & 8'h7F; end
      if (r >= 4 && r < 8) begin c_we = 1; c_wd = 7'($urandom); end
      if (r >= 8 && r < 10) inv = 1;
      if (r >= 10 && r < 13) ovf = 1;
      if (r >= 13 && r < 16) begin f_we = 1; f_wd = 8'b0011_1111; end
      b_v = ($urandom_range(0, 3) != 0);
      b_ty = 3'($urandom);
      b_sl = 2'($urandom_range(0, 2));
      b_tl = (b_ty >= 3'd6) ? 2'($urandom_range(0, 2)) : b_sl;
      b_src = $urandom; b_tgt = $urandom;
      b_mp = 1'($urandom);
      b_cyc = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 300)) : 16'($urandom);
      b_unk = ($urandom_range(0, 9) == 0);
      cyc();
      if (it % 100 == 99) read_all("R2 R3 R5 R6 R7 R8 R9 R10 R11 random");
    end
    read_all("R4 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule